// File: doc/BRIEF.md
# Protected Nonvolatile Byte Write Sequencer

This block sits behind a CPU register port and controls a 128-byte nonvolatile data store. Software uses three registers. One holds the byte address, one holds the data byte, and the third is a control register. Before a program operation can start, a guard flag has to be raised. That flag drops by itself after a short, fixed window. An accepted operation then runs for a duration that depends on its mode. During that time the block reports itself busy and refuses to change its address or mode. The storage cells are a register array. All durations are parameters counted in clock cycles.

A read strobe places the addressed byte in the data register on the next cycle. A stall output tells the CPU how long to hold after a read or after the start of a program operation. A level ready request is raised whenever software has enabled it and no operation is running. Register writes are single beats that are always accepted, so there is no stream handshake and no back-pressure.

There are two resets. `por_n` is the power-on reset for the whole block. `rst_n` is a system reset that leaves an operation already in progress running to its end.

Top module: `nvm_seq_ctrl`

## Requirements
- R1: Writing the control register with bit 2 set raises `arm_q`. Hardware lowers it again exactly ARM_WIN cycles after that write. A program request in the ARM_WIN-th cycle after the arming write is still accepted, and one in any later cycle is not.
- R2: An operation starts only when a control write has bit 1 set, `arm_q` was already high before that write, no operation is busy, and the mode is not 11. A request written without a prior arm, or in the same write as the arm, has no effect.
- R3: The mode used is the value of `mode_q` held before the request (control bits 5:4). Each mode has its own effect and duration:
  - 00 stores the data byte, taking T_BOTH cycles.
  - 01 sets the byte to 0xFF, taking T_ERASE cycles.
  - 10 ANDs the data into the stored byte, taking T_WRITE cycles.
  - 11 never starts.
- R4: `prog_q` is high for exactly the operation's duration. It falls in the same cycle as the array update, and the address and data are the values captured at the start.
- R5: While `prog_q` is high, these writes and strobes are ignored:
  - address writes (select 0);
  - mode-field writes;
  - read strobes (control bit 0).
- R6: A read strobe when not busy loads `data_q` with the byte at `addr_q` on the next cycle. Writes with select 1 load `data_q` directly, and select 3 is ignored.
- R7: `stall` is high for STALL_RD cycles after an accepted read strobe and for STALL_PG cycles after an operation starts.
- R8: `irq` is high exactly when the ready enable (control bit 3) is set and `prog_q` is low.
- R9: While `rst_n` is low, the following happen:
  - address, data, arm, ready enable and stall are cleared;
  - mode returns to 00 unless an operation is busy;
  - a busy operation runs on to completion.
  `por_n` low clears everything and sets every stored byte to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low; an operation in progress continues |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 address, 1 data, 2 control, 3 unused |
| reg_wdata | input | 8 | Write data |
| addr_q | output | 7 | Address register |
| data_q | output | 8 | Data register |
| mode_q | output | 2 | Operation mode |
| arm_q | output | 1 | Guard flag |
| prog_q | output | 1 | Operation busy |
| rdy_ie_q | output | 1 | Ready-request enable |
| stall | output | 1 | CPU hold request |
| irq | output | 1 | Ready request, level |

## Verification
The bench builds the block with ARM_WIN 4, T_BOTH 10, T_ERASE 5, T_WRITE 6, STALL_RD 4 and STALL_PG 2. These short durations let every mode run to completion several times. They also allow system resets and ignored writes to land in the middle of a busy period, and the measured busy length to be compared per mode. With the window at 4, both the last accepted cycle and the first rejected cycle after an arm are reached directly.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  typedef enum logic [1:0] {
    NV_BOTH  = 2'b00,
    NV_ERASE = 2'b01,
    NV_WRITE = 2'b10,
    NV_RSVD  = 2'b11
  } nv_mode_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int unsigned CB_RD   = 0;
  localparam int unsigned CB_PROG = 1;
  localparam int unsigned CB_ARM  = 2;
  localparam int unsigned CB_IE   = 3;
  localparam int unsigned CB_MODE = 4;
endpackage

// File: rtl/nvm_down_timer.sv
module nvm_down_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         active,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)        cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
  assign last   = (cnt == W'(1));
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
  import nvm_seq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          commit,
  input  nv_mode_e      op_mode,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (commit) begin
      case (op_mode)
        NV_BOTH:  cells[wr_addr] <= wr_data;
        NV_ERASE: cells[wr_addr] <= '1;
        NV_WRITE: cells[wr_addr] <= cells[wr_addr] & wr_data;
        default:  cells[wr_addr] <= cells[wr_addr];
      endcase
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
  import nvm_seq_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int DW       = 8,
  parameter int ARM_WIN  = 4,
  parameter int T_BOTH   = 27200,
  parameter int T_ERASE  = 14400,
  parameter int T_WRITE  = 14400,
  parameter int STALL_RD = 4,
  parameter int STALL_PG = 2,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic [1:0]    mode_q,
  output logic          arm_q,
  output logic          prog_q,
  output logic          rdy_ie_q,
  output logic          stall,
  output logic          irq
);
  localparam int TMAX1 = (T_BOTH > T_ERASE) ? T_BOTH : T_ERASE;
  localparam int TMAX  = (TMAX1 > T_WRITE) ? TMAX1 : T_WRITE;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int SMAX  = (STALL_RD > STALL_PG) ? STALL_RD : STALL_PG;
  localparam int SW    = $clog2(SMAX + 1);
  localparam int ARW   = $clog2(ARM_WIN + 1);

  logic          sys_rst_n;
  logic          ctrl_wr, start_go, read_go, op_last;
  logic [TW-1:0] dur;
  logic [SW-1:0] stall_val;
  nv_mode_e      mode_r, op_mode;
  logic [AW-1:0] addr_r, op_addr;
  logic [DW-1:0] data_r, op_data, rd_byte;
  logic          ie_r;

  assign sys_rst_n = rst_n & por_n;
  assign ctrl_wr   = reg_we && (reg_sel == SEL_CTRL);
  // arm_q is cleared asynchronously by rst_n, so a request under reset is blocked
  assign start_go  = ctrl_wr && reg_wdata[CB_PROG] && arm_q && !prog_q
                     && (mode_r != NV_RSVD);
  assign read_go   = ctrl_wr && reg_wdata[CB_RD] && !prog_q && !start_go && rst_n;

  always_comb begin
    case (mode_r)
      NV_ERASE: dur = TW'(T_ERASE);
      NV_WRITE: dur = TW'(T_WRITE);
      default:  dur = TW'(T_BOTH);
    endcase
  end

  assign stall_val = start_go ? SW'(STALL_PG) : SW'(STALL_RD);

  nvm_down_timer #(.W(TW)) u_busy (
    .clk(clk), .arst_n(por_n), .load(start_go), .load_val(dur),
    .active(prog_q), .last(op_last)
  );

  nvm_down_timer #(.W(ARW)) u_arm (
    .clk(clk), .arst_n(sys_rst_n),
    .load(ctrl_wr && reg_wdata[CB_ARM]), .load_val(ARW'(ARM_WIN)),
    .active(arm_q), .last()
  );

  nvm_down_timer #(.W(SW)) u_stall (
    .clk(clk), .arst_n(sys_rst_n),
    .load(start_go || read_go), .load_val(stall_val),
    .active(stall), .last()
  );

  // operation snapshot, kept across rst_n
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      op_addr <= '0;
      op_data <= '0;
      op_mode <= NV_BOTH;
    end else if (start_go) begin
      op_addr <= addr_r;
      op_data <= data_r;
      op_mode <= mode_r;
    end
  end

  // mode survives rst_n while an operation runs
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                               mode_r <= NV_BOTH;
    else if (!rst_n && !prog_q)               mode_r <= NV_BOTH;
    else if (rst_n && ctrl_wr && !prog_q)     mode_r <= nv_mode_e'(reg_wdata[CB_MODE +: 2]);
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      addr_r <= '0;
      data_r <= '0;
      ie_r   <= 1'b0;
    end else begin
      if (reg_we && reg_sel == SEL_ADDR && !prog_q) addr_r <= reg_wdata[AW-1:0];
      if (reg_we && reg_sel == SEL_DATA)            data_r <= reg_wdata;
      else if (read_go)                             data_r <= rd_byte;
      if (ctrl_wr)                                  ie_r   <= reg_wdata[CB_IE];
    end
  end

  nvm_cell_array #(.DEPTH(DEPTH), .DW(DW)) u_cells (
    .clk(clk), .por_n(por_n), .commit(op_last), .op_mode(op_mode),
    .wr_addr(op_addr), .wr_data(op_data), .rd_addr(addr_r), .rd_data(rd_byte)
  );

  assign addr_q   = addr_r;
  assign data_q   = data_r;
  assign mode_q   = mode_r;
  assign rdy_ie_q = ie_r;
  assign irq      = ie_r && !prog_q;
endmodule

// File: rtl/nvm_seq_ctrl_chk.sv
module nvm_seq_ctrl_chk #(
  parameter int ARM_WIN = 4
) (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_sel,
  input logic [7:0] reg_wdata,
  input logic [6:0] addr_q,
  input logic [1:0] mode_q,
  input logic       arm_q,
  input logic       prog_q,
  input logic       stall,
  input logic       irq
);
  int arm_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                          arm_run <= 0;
    else if (reg_we && reg_sel == 2'd2 && reg_wdata[2])  arm_run <= 1;
    else if (arm_q)                                      arm_run <= arm_run + 1;
    else                                                 arm_run <= 0;
  end

  // R1
  arm_window_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    arm_q |-> (arm_run <= ARM_WIN));

  // R2
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(prog_q) |-> $past(arm_q));

  // R5
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
    (prog_q && $past(prog_q)) |-> $stable(mode_q));

  // R5
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (prog_q && $past(prog_q) && $past(rst_n)) |-> $stable(addr_q));

  // R7
  start_stall_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(prog_q) |-> stall);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    prog_q |-> !irq);
endmodule

bind nvm_seq_ctrl nvm_seq_ctrl_chk #(.ARM_WIN(ARM_WIN)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .addr_q(addr_q), .mode_q(mode_q), .arm_q(arm_q),
  .prog_q(prog_q), .stall(stall), .irq(irq)
);

// File: tb/nvm_seq_ctrl_tb.sv
module nvm_seq_ctrl_tb;
  localparam int ARM = 4, TB = 10, TE = 5, TWR = 6, SRD = 4, SPG = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       por_n, rst_n, reg_we;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata;
  logic [6:0] addr_q;
  logic [7:0] data_q;
  logic [1:0] mode_q;
  logic       arm_q, prog_q, rdy_ie_q, stall, irq;

  nvm_seq_ctrl #(.ARM_WIN(ARM), .T_BOTH(TB), .T_ERASE(TE), .T_WRITE(TWR),
                 .STALL_RD(SRD), .STALL_PG(SPG)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .addr_q(addr_q), .data_q(data_q), .mode_q(mode_q),
    .arm_q(arm_q), .prog_q(prog_q), .rdy_ie_q(rdy_ie_q), .stall(stall), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;

  // behavioural reference
  int m_addr, m_data, m_mode, m_ie, m_arm, m_busy, m_stall, m_opa, m_opd, m_opm;
  int m_mem [128];

  always @(posedge clk) begin : model
    int pb, pa, pm;
    if (!por_n) begin
      m_addr = 0; m_data = 0; m_mode = 0; m_ie = 0; m_arm = 0;
      m_busy = 0; m_stall = 0; m_opa = 0; m_opd = 0; m_opm = 0;
      foreach (m_mem[i]) m_mem[i] = 255;
    end else begin
      pb = m_busy; pa = m_arm; pm = m_mode;
      if (m_busy == 1) begin
        if (m_opm == 0)      m_mem[m_opa] = m_opd;
        else if (m_opm == 1) m_mem[m_opa] = 255;
        else if (m_opm == 2) m_mem[m_opa] = m_mem[m_opa] & m_opd;
      end
      if (m_busy > 0)  m_busy--;
      if (m_arm > 0)   m_arm--;
      if (m_stall > 0) m_stall--;
      if (!rst_n) begin
        m_addr = 0; m_data = 0; m_ie = 0; m_arm = 0; m_stall = 0;
        if (pb == 0) m_mode = 0;
      end else if (reg_we) begin
        case (reg_sel)
          2'd0: if (pb == 0) m_addr = int'(reg_wdata) & 127;
          2'd1: m_data = int'(reg_wdata);
          2'd2: begin
            m_ie = int'(reg_wdata[3]);
            if (pb == 0) m_mode = int'(reg_wdata[5:4]);
            if (reg_wdata[2]) m_arm = ARM;
            if (reg_wdata[1] && pa > 0 && pb == 0 && pm != 3) begin
              m_busy  = (pm == 0) ? TB : (pm == 1) ? TE : TWR;
              m_opa   = m_addr; m_opd = m_data; m_opm = pm;
              m_stall = SPG;
            end else if (reg_wdata[0] && pb == 0) begin
              m_data  = m_mem[m_addr];
              m_stall = SRD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R1 arm_q", int'(arm_q), int'(m_arm > 0));
    chk("R4 prog_q", int'(prog_q), int'(m_busy > 0));
    chk("R5 mode_q", int'(mode_q), m_mode);
    chk("R5 addr_q", int'(addr_q), m_addr);
    chk("R6 data_q", int'(data_q), m_data);
    chk("R7 stall", int'(stall), int'(m_stall > 0));
    chk("R8 irq", int'(irq), int'(m_ie != 0 && m_busy == 0));
    chk("R9 rdy_ie_q", int'(rdy_ie_q), m_ie);
  endtask

  task automatic step(input logic we, input logic [1:0] sel, input logic [7:0] w);
    reg_we = we; reg_sel = sel; reg_wdata = w;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    cmp_all();
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 8'h00);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] w);
    step(1'b1, sel, w);
  endtask

  // returns number of cycles prog_q stays high, counting the start step
  task automatic run_len(output int n);
    n = prog_q ? 1 : 0;
    while (prog_q) begin
      idle(1);
      if (prog_q) n++;
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    por_n = 1'b0; rst_n = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
    @(negedge clk);
    idle(2);
    por_n = 1'b1; rst_n = 1'b1;
    idle(1);
    chk("R9 reset prog_q", int'(prog_q), 0);
    chk("R9 reset irq", int'(irq), 0);

    // power-on content is erased
    wr(2'd0, 8'd6); wr(2'd2, 8'h01);
    chk("R9 erased byte", int'(data_q), 8'hFF);
    chk("R7 read stall", int'(stall), 1);

    // combined operation
    wr(2'd0, 8'd5); wr(2'd1, 8'h3C);
    wr(2'd2, 8'h04); wr(2'd2, 8'h02);
    run_len(n);
    chk("R4 busy length both", n, TB);
    wr(2'd2, 8'h01);
    chk("R6 read after both", int'(data_q), 8'h3C);

    // requests that must be rejected
    wr(2'd1, 8'h55);
    wr(2'd2, 8'h02);
    chk("R2 no arm", int'(prog_q), 0);
    wr(2'd2, 8'h06);
    chk("R2 arm and request together", int'(prog_q), 0);
    idle(ARM + 2);
    wr(2'd2, 8'h02);
    chk("R1 request after window", int'(prog_q), 0);
    wr(2'd2, 8'h04); idle(ARM); wr(2'd2, 8'h02);
    chk("R1 one cycle late", int'(prog_q), 0);

    // last accepted cycle of the window
    wr(2'd2, 8'h04); idle(ARM - 1); wr(2'd2, 8'h02);
    chk("R1 last window cycle", int'(prog_q), 1);
    run_len(n);
    wr(2'd2, 8'h01);
    chk("R3 stored 55", int'(data_q), 8'h55);

    // erase only
    wr(2'd2, 8'h14); wr(2'd2, 8'h12);
    run_len(n);
    chk("R3 erase length", n, TE);
    wr(2'd2, 8'h11);
    chk("R3 erase gives FF", int'(data_q), 8'hFF);

    // write only, twice without erase: AND
    wr(2'd1, 8'h3C); wr(2'd2, 8'h24); wr(2'd2, 8'h22);
    run_len(n);
    chk("R3 write length", n, TWR);
    wr(2'd1, 8'hF0); wr(2'd2, 8'h24); wr(2'd2, 8'h22);
    run_len(n);
    wr(2'd2, 8'h21);
    chk("R3 write-only AND", int'(data_q), 8'h30);

    // reserved mode
    wr(2'd2, 8'h34); wr(2'd2, 8'h32);
    chk("R3 reserved mode", int'(prog_q), 0);

    // ignored accesses while busy
    wr(2'd1, 8'hA5); wr(2'd2, 8'h04); wr(2'd2, 8'h02);
    idle(SPG);
    wr(2'd0, 8'd9);
    chk("R5 addr frozen", int'(addr_q), 5);
    wr(2'd2, 8'h10);
    chk("R5 mode frozen", int'(mode_q), 0);
    wr(2'd2, 8'h01);
    chk("R5 read ignored stall", int'(stall), 0);
    chk("R5 read ignored data", int'(data_q), 8'hA5);
    wr(2'd2, 8'h08);
    chk("R8 no irq while busy", int'(irq), 0);
    run_len(n);
    chk("R8 irq when ready", int'(irq), 1);
    wr(2'd2, 8'h01);
    chk("R4 committed value", int'(data_q), 8'hA5);
    wr(2'd3, 8'h00);
    chk("R6 select 3 ignored", int'(data_q), 8'hA5);

    // system reset during an operation
    wr(2'd2, 8'h2C); wr(2'd2, 8'h2A);
    rst_n = 1'b0;
    idle(2);
    chk("R9 mode kept while busy", int'(mode_q), 2);
    chk("R9 op continues", int'(prog_q), 1);
    rst_n = 1'b1;
    run_len(n);
    chk("R9 mode after op", int'(mode_q), 2);
    rst_n = 1'b0;
    idle(1);
    chk("R9 mode cleared idle", int'(mode_q), 0);
    rst_n = 1'b1;
    idle(2);
    finish_run();
  end
endmodule